// File: doc/BRIEF.md
# SRAM Chip-Enable Write-Protect Gate

This block sits in the chip-enable path between a host and a static RAM. While the supply is healthy it passes the host's active-low enable straight to the memory, with no clock delay. When an external comparator reports that the supply has left tolerance, the gate stops new accesses from reaching the memory. An access that is already running may finish, but only within a bounded grace window.

After the supply recovers, the gate keeps the memory protected for a long recovery interval, so that a supply that is still settling cannot corrupt the array. The power-fail flag passes through a reset-to-fail synchroniser before it is used. Both timer lengths are parameters counted in clock cycles, so a simulation can use short windows. An asynchronous reset puts the gate in its protected state.

Top module: `sram_ce_guard`

## Requirements
- R1: In the pass-through state, `ce_out_n` equals `ce_in_n` combinationally, within the same clock cycle and with no register on the path.
- R2: If `ce_in_n` is high (1) when the synchronised fail flag is seen, `ce_out_n` stays high. A later drop of `ce_in_n` to 0 during the fail period does not pull `ce_out_n` low.
- R3: If `ce_in_n` is low when the fail is seen, `ce_out_n` stays low until `ce_in_n` rises. From that moment `ce_out_n` is 1, even if `ce_in_n` falls again.
- R4: If the host keeps `ce_in_n` low, `ce_out_n` is forced to 1 on the (GRACE_CYCLES+3)-th rising edge after `pwr_fail_i` rises. This count includes two synchroniser edges and one decision edge.
- R5: Once forced high, `ce_out_n` stays 1 for as long as `pwr_fail_i` stays asserted.
- R6: After `pwr_fail_i` falls, `ce_out_n` stays 1 until the (RECOVER_CYCLES+3)-th rising edge. From that edge on it follows `ce_in_n`.
- R7: If `pwr_fail_i` rises again during recovery, the recovery count is abandoned and `ce_out_n` stays 1. A full recovery interval, as in R6, starts from the next fall of `pwr_fail_i`.
- R8: While `rst_n` is low, `ce_out_n` is 1 and the synchroniser reads "fail". With `pwr_fail_i` low, pass-through resumes on the (RECOVER_CYCLES+3)-th rising edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the synchroniser and both timers |
| rst_n | input | 1 | Asynchronous active-low reset into the protected state |
| pwr_fail_i | input | 1 | Supply-out-of-tolerance flag from the comparator, 1 = fail |
| ce_in_n | input | 1 | Host chip enable, active low |
| ce_out_n | output | 1 | Memory chip enable, active low |

## Verification
Pass-through results are due in the same cycle: after changing `ce_in_n`, the bench waits 1 ns and samples, with no clock edge in between. Every fail or recovery result is due on a fixed rising edge after `pwr_fail_i` changes. That edge is GRACE_CYCLES+3 for the forced block and RECOVER_CYCLES+3 for the return to pass-through. The bench counts edges from the input change and samples 2 ns after each edge, computing the expected level of `ce_out_n` arithmetically from that edge index. The grace sweep releases `ce_in_n` after every edge index from 0 to GRACE_CYCLES+4, so every release point before and after the forced block is covered.

// File: rtl/sceg_pkg.sv
package sceg_pkg;

    typedef enum logic [1:0] {
        GS_PASS    = 2'd0,
        GS_GRACE   = 2'd1,
        GS_LOCKED  = 2'd2,
        GS_RECOVER = 2'd3
    } guard_state_e;

    typedef struct packed {
        guard_state_e st;
        logic         latched;
    } guard_regs_t;

endpackage

// File: rtl/sceg_sync.sv
module sceg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sceg_timer.sv
module sceg_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sram_ce_guard.sv
module sram_ce_guard
    import sceg_pkg::*;
#(
    parameter int GRACE_CYCLES   = 8,
    parameter int RECOVER_CYCLES = 32,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail_i,
    input  logic ce_in_n,
    output logic ce_out_n
);
    localparam int MAXC = (GRACE_CYCLES > RECOVER_CYCLES) ? GRACE_CYCLES : RECOVER_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] GRACE_LAST   = CW'(GRACE_CYCLES - 1);
    localparam logic [CW-1:0] RECOVER_LAST = CW'(RECOVER_CYCLES - 1);

    guard_regs_t   r_d, r_q;
    logic          pf_sync;
    logic          tmr_clr, tmr_inc;
    logic [CW-1:0] tmr_cnt;
    guard_state_e  st_now;
    logic          out_n;

    sceg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pwr_fail_i),
        .q_o   (pf_sync)
    );

    sceg_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .inc_i (tmr_inc),
        .cnt_o (tmr_cnt)
    );

    always_comb begin
        r_d     = r_q;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        out_n   = 1'b1;
        unique case (r_q.st)
            GS_PASS: begin
                out_n = ce_in_n;
                if (pf_sync) begin
                    tmr_clr = 1'b1;
                    if (ce_in_n) begin
                        r_d.st      = GS_LOCKED;
                        r_d.latched = 1'b1;
                    end else begin
                        r_d.st = GS_GRACE;
                    end
                end
            end
            GS_GRACE: begin
                out_n = ce_in_n;
                if (ce_in_n || (tmr_cnt == GRACE_LAST)) begin
                    r_d.st      = GS_LOCKED;
                    r_d.latched = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            GS_LOCKED: begin
                if (!pf_sync) begin
                    r_d.st  = GS_RECOVER;
                    tmr_clr = 1'b1;
                end
            end
            GS_RECOVER: begin
                if (pf_sync) begin
                    r_d.st = GS_LOCKED;
                end else if (tmr_cnt == RECOVER_LAST) begin
                    r_d.st      = GS_PASS;
                    r_d.latched = 1'b0;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            default: r_d.st = GS_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: GS_LOCKED, latched: 1'b1};
        else        r_q <= r_d;
    end

    assign st_now   = r_q.st;
    assign ce_out_n = out_n;
endmodule

// File: rtl/sceg_checker.sv
module sceg_checker
    import sceg_pkg::*;
#(
    parameter int GRACE_CYCLES   = 8,
    parameter int RECOVER_CYCLES = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ce_in_n,
    input logic         ce_out_n,
    input logic         pf_sync,
    input guard_state_e st
);
    localparam int GW = $clog2(GRACE_CYCLES + 2) + 1;
    localparam int RW = $clog2(RECOVER_CYCLES + 3) + 1;
    localparam logic [RW-1:0] GOOD_SAT = RW'(RECOVER_CYCLES + 2);

    logic [GW-1:0] grace_age;
    logic [RW-1:0] good_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grace_age <= '0;
            good_age  <= '0;
        end else begin
            grace_age <= (st == GS_GRACE) ? grace_age + 1'b1 : '0;
            if (pf_sync)                good_age <= '0;
            else if (good_age != GOOD_SAT) good_age <= good_age + 1'b1;
        end
    end

    always_comb begin
        if (rst_n === 1'b0) begin
            AST_RESET_HIGH: assert (ce_out_n); // R8
        end
    end

    AST_FAIL_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_sync && ce_out_n && st != GS_GRACE) |=> ce_out_n); // R5
    AST_GRACE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_GRACE && ce_in_n) |=> ce_out_n); // R3
    AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_GRACE) |-> (grace_age < GW'(GRACE_CYCLES))); // R4
    AST_RECOVER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_out_n && st != GS_GRACE) |-> (good_age >= RW'(RECOVER_CYCLES))); // R6
    AST_REFAIL_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GS_RECOVER && pf_sync) |=> (st == GS_LOCKED && ce_out_n)); // R7
endmodule

bind sram_ce_guard sceg_checker #(
    .GRACE_CYCLES   (GRACE_CYCLES),
    .RECOVER_CYCLES (RECOVER_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_in_n  (ce_in_n),
    .ce_out_n (ce_out_n),
    .pf_sync  (pf_sync),
    .st       (st_now)
);

// File: tb/sram_ce_guard_test.sv
`timescale 1ns/1ps
module sram_ce_guard_test;
    localparam int G = 8;
    localparam int R = 32;

    logic clk = 1'b0;
    logic rst_n, pf, ce;
    logic out_n;
    int   total = 0;
    int   bad   = 0;

    always #5 clk = ~clk;

    sram_ce_guard #(.GRACE_CYCLES(G), .RECOVER_CYCLES(R), .SYNC_STAGES(2)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_fail_i (pf),
        .ce_in_n    (ce),
        .ce_out_n   (out_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s ce_out_n=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // pwr_fail_i falls now with ce low; count edges to pass-through
    task automatic recover_checked(input string req);
        ce = 1'b0;
        pf = 1'b0;
        for (int e = 1; e <= R + 3; e++) begin
            tick();
            chk(req, out_n, (e >= R + 3) ? 1'b0 : 1'b1);
        end
    endtask

    task automatic lock_idle();
        ce = 1'b1;
        pf = 1'b1;
        repeat (4) tick();
        ce = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pf = 1'b0; ce = 1'b1; rst_n = 1'b0;
        repeat (3) tick();
        ce = 1'b0;
        #1 chk("R8 in reset", out_n, 1'b1);
        rst_n = 1'b1;
        for (int e = 1; e <= R + 3; e++) begin
            tick();
            chk("R8 after release", out_n, (e >= R + 3) ? 1'b0 : 1'b1);
        end

        // R1: combinational follow, inside and across cycles
        for (int i = 0; i < 16; i++) begin
            ce = ~ce;
            #1 chk("R1 follow", out_n, ce);
            if (i % 3 == 0) tick();
        end

        // R2: idle enable at fail, then host drops enable
        for (int k = 3; k <= 6; k++) begin
            ce = 1'b1; pf = 1'b1;
            repeat (k) tick();
            ce = 1'b0;
            #1 chk("R2 idle lock", out_n, 1'b1);
            for (int j = 0; j < 3; j++) begin
                tick();
                chk("R5 hold", out_n, 1'b1);
            end
            recover_checked("R6 recovery");
        end

        // R3/R4: release the access after every edge index
        for (int k = 0; k <= G + 4; k++) begin
            bit released;
            ce = 1'b0; pf = 1'b1;
            released = (k == 0);
            if (released) begin
                ce = 1'b1;
                #1 chk("R3 release", out_n, 1'b1);
            end
            for (int e = 1; e <= G + 5; e++) begin
                tick();
                if (released) chk("R3 latched", out_n, 1'b1);
                else          chk("R4 grace", out_n, (e >= G + 3) ? 1'b1 : 1'b0);
                if (!released && e == k) begin
                    ce = 1'b1;
                    released = 1'b1;
                    #1 chk("R3 release", out_n, 1'b1);
                end
            end
            ce = 1'b0;
            #1 chk("R3 relower", out_n, 1'b1);
            for (int j = 0; j < 3; j++) begin
                tick();
                chk("R5 hold", out_n, 1'b1);
            end
            recover_checked("R6 recovery");
        end

        // R7: fail returns during recovery
        for (int v = 0; v < 3; v++) begin
            int m;
            m = (v == 0) ? 1 : (v == 1) ? R / 2 : R - 1;
            lock_idle();
            pf = 1'b0;
            for (int j = 0; j < m; j++) begin
                tick();
                chk("R7 early recovery", out_n, 1'b1);
            end
            pf = 1'b1;
            for (int j = 0; j < 4; j++) begin
                tick();
                chk("R7 refail", out_n, 1'b1);
            end
            recover_checked("R7 full restart");
        end

        ce = 1'b1;
        #1 chk("R1 final follow", out_n, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule